// File: doc/BRIEF.md
# Two-Channel Debug Break Comparator

This unit watches a processor's bus and instruction-fetch traffic and asks for a debug break when a programmed condition is seen. It has two comparison channels, A and B. Each channel checks the bus address under a per-bit ignore mask and qualifies the match by access direction (read or write) and access kind (instruction fetch or operand). Channel B can also compare the data bus value under its own per-bit ignore mask, together with the operand size.

A 16-bit control word decides how the two channel results become a break. In independent mode, a match on either channel requests a break. In sequential mode, a channel-A match only arms channel B, and the break comes from a later channel-B match. For instruction-fetch matches, each channel can break before execution, on the match itself, or after execution, on the completion strobe of that instruction. Sticky match flags in the control word record which channel has matched. A debug-route output tells the exception logic whether to send the break to the user-break debug path.

Software programs the unit through a small select/write port with a combinational read-back. The monitored bus is sampled on every cycle that `bus_valid` is high.

Top module: `bkpt_pair`

## Requirements
- R1: After synchronous reset, `brk_req` and `brk_dbg` are 0 and the control word (select 8) reads 0x0000.
- R2: A channel's address matches when `(bus_addr ^ addr) & ~addr_mask` is zero, so mask bit 1 means ignore. Channel A registers sit at selects 0 (address), 1 (mask) and 2 (cycle attributes). Channel B registers sit at selects 3, 4 and 5.
- R3: The cycle-attribute register qualifies a match. Bit 0 allows reads, bit 1 allows writes, bit 2 allows instruction fetches and bit 3 allows operand accesses. An access whose direction or kind is not allowed never matches.
- R4: When control bit 7 is 1, channel B also requires `(bus_data ^ data) & ~data_mask` to be zero (data at select 6, mask at select 7, mask bit 1 means ignore). In that case, attribute bits [5:4] must equal `bus_size` unless they are 00 (encoding: 01 byte, 10 word, 11 long). When bit 7 is 0, data and size are ignored.
- R5: A channel match sets its flag: bit 15 for A, bit 14 for B. A flag stays set until software writes 0 to that bit. Writing 1 to a flag has no effect.
- R6: In independent mode (control bit 0 = 0), a match on either channel causes `brk_req` to be high for one cycle, starting the cycle after the matching access.
- R7: In sequential mode (control bit 0 = 1), a channel-A match sets flag A and arms channel B but does not break. A channel-B match breaks and sets flag B only while armed, and that break clears the arm.
- R8: If a channel's post-execution bit (bit 10 for A, bit 6 for B) is 1, a break from an instruction-fetch match is held until `insn_done`, and `brk_req` pulses the cycle after that strobe. Operand-access matches always break immediately.
- R9: `brk_dbg` is high exactly with `brk_req` when control bit 3 is 1, and it is 0 otherwise.
- R10: Control bits 10, 7, 6, 3 and 0 read back as written. All other control bits, apart from the flags, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Combinational read-back of the selected register |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_addr | input | 32 | Access address |
| bus_data | input | 32 | Access data |
| bus_size | input | 2 | Operand size: 01 byte, 10 word, 11 long |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_ifetch | input | 1 | 1 = instruction fetch, 0 = operand |
| insn_done | input | 1 | Completion strobe of the pending instruction |
| brk_req | output | 1 | Break request pulse |
| brk_dbg | output | 1 | Route break to the debug path |

## Verification
An immediate break and a flag update are both registered once. They therefore appear one clock edge after the access cycle, and the bench samples them at the next falling edge after driving the access. A deferred break appears one edge after `insn_done`. The bench checks that `brk_req` is still 0 on the cycles between the fetch match and the strobe, and that it returns to 0 on the cycle after the pulse. Register writes take effect at the next edge, and read-back is combinational, so every read is taken a moment after the select changes on a falling edge.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int SEL_W   = 4;
    localparam int CTRL_W  = 16;
    localparam int N_CH    = 2;
    localparam int ATTR_W  = 6;
    localparam int STRIDE  = 3;

    // register selects
    localparam logic [SEL_W-1:0] SEL_DATA_B = SEL_W'(N_CH * STRIDE);
    localparam logic [SEL_W-1:0] SEL_DMSK_B = SEL_W'(N_CH * STRIDE + 1);
    localparam logic [SEL_W-1:0] SEL_CTRL   = SEL_W'(N_CH * STRIDE + 2);

    // control bit positions
    localparam int CB_FLAG_A = 15;
    localparam int CB_FLAG_B = 14;
    localparam int CB_POST_A = 10;
    localparam int CB_DEN_B  = 7;
    localparam int CB_POST_B = 6;
    localparam int CB_DBG    = 3;
    localparam int CB_SEQ    = 0;

    typedef struct packed {
        logic [1:0] size;
        logic       oper;
        logic       ifetch;
        logic       wr;
        logic       rd;
    } cyc_attr_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] amask;
        cyc_attr_t         attr;
    } chan_cfg_t;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [1:0]        size;
        logic              write;
        logic              ifetch;
    } bus_obs_t;

    typedef struct packed {
        logic flag_a;
        logic flag_b;
        logic post_a;
        logic den_b;
        logic post_b;
        logic dbg_en;
        logic seq;
    } ctrl_t;

    function automatic logic masked_equal(input logic [DATA_W-1:0] a,
                                          input logic [DATA_W-1:0] b,
                                          input logic [DATA_W-1:0] ign);
        return ((a ^ b) & ~ign) == '0;
    endfunction

    function automatic logic [CTRL_W-1:0] ctrl_image(input ctrl_t c);
        logic [CTRL_W-1:0] v;
        v            = '0;
        v[CB_FLAG_A] = c.flag_a;
        v[CB_FLAG_B] = c.flag_b;
        v[CB_POST_A] = c.post_a;
        v[CB_DEN_B]  = c.den_b;
        v[CB_POST_B] = c.post_b;
        v[CB_DBG]    = c.dbg_en;
        v[CB_SEQ]    = c.seq;
        return v;
    endfunction

endpackage

// File: rtl/bkpt_chan_cmp.sv
module bkpt_chan_cmp
    import bkpt_pkg::*;
#(
    parameter bit WITH_DATA = 1'b0
) (
    input  chan_cfg_t         cfg,
    input  bus_obs_t          bus,
    input  logic              data_en,
    input  logic [DATA_W-1:0] dval,
    input  logic [DATA_W-1:0] dmask,
    output logic              hit
);

    logic addr_ok;
    logic kind_ok;
    logic dir_ok;
    logic data_ok;

    always_comb begin
        addr_ok = masked_equal(bus.addr, cfg.addr, cfg.amask);
        kind_ok = bus.ifetch ? cfg.attr.ifetch : cfg.attr.oper;
        dir_ok  = bus.write  ? cfg.attr.wr     : cfg.attr.rd;
    end

    if (WITH_DATA) begin : g_data
        logic size_ok;
        always_comb begin
            size_ok = (cfg.attr.size == 2'b00) || (cfg.attr.size == bus.size);
            data_ok = !data_en || (masked_equal(bus.data, dval, dmask) && size_ok);
        end
    end else begin : g_nodata
        logic unused_data;
        assign unused_data = ^{data_en, dval, dmask, cfg.attr.size, bus.data, bus.size};
        assign data_ok     = 1'b1;
    end

    assign hit = bus.valid && addr_ok && kind_ok && dir_ok && data_ok;

endmodule

// File: rtl/bkpt_regs.sv
module bkpt_regs
    import bkpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              set_a,
    input  logic              set_b,
    output chan_cfg_t         cfg [N_CH],
    output logic [DATA_W-1:0] dval,
    output logic [DATA_W-1:0] dmask,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] rdata
);

    logic wr_ctrl;
    assign wr_ctrl = we && (sel == SEL_CTRL);

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        localparam logic [SEL_W-1:0] BASE = SEL_W'(ch * STRIDE);
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[ch] <= '0;
            end else if (we) begin
                if (sel == BASE)      cfg[ch].addr  <= wdata[ADDR_W-1:0];
                if (sel == BASE + 1)  cfg[ch].amask <= wdata[ADDR_W-1:0];
                if (sel == BASE + 2)  cfg[ch].attr  <= cyc_attr_t'(wdata[ATTR_W-1:0]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dval  <= '0;
            dmask <= '0;
        end else if (we) begin
            if (sel == SEL_DATA_B) dval  <= wdata;
            if (sel == SEL_DMSK_B) dmask <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl.post_a <= wdata[CB_POST_A];
                ctrl.den_b  <= wdata[CB_DEN_B];
                ctrl.post_b <= wdata[CB_POST_B];
                ctrl.dbg_en <= wdata[CB_DBG];
                ctrl.seq    <= wdata[CB_SEQ];
            end
            ctrl.flag_a <= set_a || (ctrl.flag_a && !(wr_ctrl && !wdata[CB_FLAG_A]));
            ctrl.flag_b <= set_b || (ctrl.flag_b && !(wr_ctrl && !wdata[CB_FLAG_B]));
        end
    end

    always_comb begin
        rdata = '0;
        for (int ch = 0; ch < N_CH; ch++) begin
            if (sel == SEL_W'(ch * STRIDE))     rdata = DATA_W'(cfg[ch].addr);
            if (sel == SEL_W'(ch * STRIDE + 1)) rdata = DATA_W'(cfg[ch].amask);
            if (sel == SEL_W'(ch * STRIDE + 2)) rdata = DATA_W'(cfg[ch].attr);
        end
        if (sel == SEL_DATA_B) rdata = dval;
        if (sel == SEL_DMSK_B) rdata = dmask;
        if (sel == SEL_CTRL)   rdata = DATA_W'(ctrl_image(ctrl));
    end

    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        set_a |=> ctrl.flag_a);

    // R5
    flag_one_write_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.flag_b && wr_ctrl && wdata[CB_FLAG_B]) |=> ctrl.flag_b);

    // R5
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !wdata[CB_FLAG_A] && !set_a) |=> !ctrl.flag_a);

endmodule

// File: rtl/bkpt_seq.sv
module bkpt_seq
    import bkpt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl,
    input  logic  hit_a,
    input  logic  hit_b,
    input  logic  fetch,
    input  logic  insn_done,
    output logic  set_a,
    output logic  set_b,
    output logic  brk_req,
    output logic  brk_dbg
);

    logic arm_q;
    logic pend_q;
    logic fire_a;
    logic fire_b;
    logic defer;
    logic now;
    logic fire;

    always_comb begin
        fire_a = hit_a && !ctrl.seq;
        fire_b = hit_b && (!ctrl.seq || arm_q);
        set_a  = hit_a;
        set_b  = fire_b;
        defer  = (fire_a && ctrl.post_a && fetch) || (fire_b && ctrl.post_b && fetch);
        now    = (fire_a && !(ctrl.post_a && fetch)) || (fire_b && !(ctrl.post_b && fetch));
        fire   = now || (pend_q && insn_done);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q   <= 1'b0;
            pend_q  <= 1'b0;
            brk_req <= 1'b0;
            brk_dbg <= 1'b0;
        end else begin
            if (!ctrl.seq)             arm_q <= 1'b0;
            else if (hit_b && arm_q)   arm_q <= 1'b0;
            else if (hit_a)            arm_q <= 1'b1;
            pend_q  <= (pend_q && !insn_done) || defer;
            brk_req <= fire;
            brk_dbg <= fire && ctrl.dbg_en;
        end
    end

    // R7
    seq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.seq && !arm_q && !pend_q) |=> !brk_req);

    // R7
    seq_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.seq && hit_a && !hit_b) |=> arm_q);

    // R8
    post_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.seq && ctrl.post_a && hit_a && fetch && !hit_b && !pend_q) |=> !brk_req);

endmodule

// File: rtl/bkpt_pair.sv
module bkpt_pair
    import bkpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [1:0]        bus_size,
    input  logic              bus_write,
    input  logic              bus_ifetch,
    input  logic              insn_done,
    output logic              brk_req,
    output logic              brk_dbg
);

    chan_cfg_t         cfg [N_CH];
    logic [DATA_W-1:0] dval;
    logic [DATA_W-1:0] dmask;
    ctrl_t             ctrl;
    bus_obs_t          bus;
    logic [N_CH-1:0]   hits;
    logic              set_a;
    logic              set_b;

    always_comb begin
        bus.valid  = bus_valid;
        bus.addr   = bus_addr;
        bus.data   = bus_data;
        bus.size   = bus_size;
        bus.write  = bus_write;
        bus.ifetch = bus_ifetch;
    end

    bkpt_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .set_a (set_a),
        .set_b (set_b),
        .cfg   (cfg),
        .dval  (dval),
        .dmask (dmask),
        .ctrl  (ctrl),
        .rdata (cfg_rdata)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_cmp
        bkpt_chan_cmp #(.WITH_DATA(ch == N_CH - 1)) u_cmp (
            .cfg     (cfg[ch]),
            .bus     (bus),
            .data_en (ctrl.den_b),
            .dval    (dval),
            .dmask   (dmask),
            .hit     (hits[ch])
        );
    end

    bkpt_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .hit_a     (hits[0]),
        .hit_b     (hits[N_CH-1]),
        .fetch     (bus_valid && bus_ifetch),
        .insn_done (insn_done),
        .set_a     (set_a),
        .set_b     (set_b),
        .brk_req   (brk_req),
        .brk_dbg   (brk_dbg)
    );

    // R9
    dbg_sub_chk: assert property (@(posedge clk) disable iff (rst)
        brk_dbg |-> brk_req);

endmodule

// File: tb/sim_bkpt_pair.sv
module sim_bkpt_pair;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_data = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_write = 1'b0;
    logic        bus_ifetch = 1'b0;
    logic        insn_done = 1'b0;
    logic        brk_req;
    logic        brk_dbg;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bkpt_pair u0 (
        .clk (clk), .rst (rst),
        .cfg_we (cfg_we), .cfg_sel (cfg_sel), .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata),
        .bus_valid (bus_valid), .bus_addr (bus_addr), .bus_data (bus_data),
        .bus_size (bus_size), .bus_write (bus_write), .bus_ifetch (bus_ifetch),
        .insn_done (insn_done), .brk_req (brk_req), .brk_dbg (brk_dbg)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] data;
        logic [1:0]  size;
        logic        write;
        logic        ifetch;
        logic        exp;
    } vec_t;

    // A: addr 0x1000 mask 0xF, fetch+read. B: 0x20000000, operand r/w, long, data 0xCAFExxxx
    localparam vec_t VECS [NVEC] = '{
        {32'h0000_1000, 32'h0,         2'b11, 1'b0, 1'b1, 1'b1},  // R2 exact
        {32'h0000_100C, 32'h0,         2'b11, 1'b0, 1'b1, 1'b1},  // R2 masked bits
        {32'h0000_1010, 32'h0,         2'b11, 1'b0, 1'b1, 1'b0},  // R2 unmasked bit differs
        {32'h0000_1004, 32'h0,         2'b11, 1'b0, 1'b0, 1'b0},  // R3 operand kind not allowed
        {32'h0000_1004, 32'h0,         2'b11, 1'b1, 1'b1, 1'b0},  // R3 write not allowed
        {32'h2000_0000, 32'hCAFE_1234, 2'b11, 1'b1, 1'b0, 1'b1},  // R4 data match, low half ignored
        {32'h2000_0000, 32'hCAFF_1234, 2'b11, 1'b1, 1'b0, 1'b0},  // R4 compared bit differs
        {32'h2000_0000, 32'hCAFE_0000, 2'b10, 1'b0, 1'b0, 1'b0},  // R4 size mismatch
        {32'h2000_0000, 32'hCAFE_0000, 2'b11, 1'b0, 1'b0, 1'b1},  // R6 channel B read
        {32'h2000_0000, 32'hCAFE_0000, 2'b11, 1'b0, 1'b1, 1'b0}   // R3 fetch not allowed on B
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] s, input logic [31:0] d);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] s, output logic [31:0] d);
        cfg_sel = s;
        #1;
        d = cfg_rdata;
    endtask

    task automatic access(input logic [31:0] a, input logic [31:0] d, input logic [1:0] sz,
                          input logic w, input logic f, output logic b, output logic g);
        bus_valid = 1'b1; bus_addr = a; bus_data = d; bus_size = sz;
        bus_write = w; bus_ifetch = f;
        @(negedge clk);
        b = brk_req; g = brk_dbg;
        bus_valid = 1'b0;
    endtask

    task automatic idle(output logic b);
        @(negedge clk);
        b = brk_req;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [31:0] r;
        logic b, g;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd(4'd8, r);
        chk("R1 ctrl after reset", r, 32'h0);
        chk("R1 brk_req after reset", {31'b0, brk_req}, 32'h0);
        chk("R1 brk_dbg after reset", {31'b0, brk_dbg}, 32'h0);

        wr(4'd0, 32'h0000_1000);
        wr(4'd1, 32'h0000_000F);
        wr(4'd2, 32'h0000_0005);
        wr(4'd3, 32'h2000_0000);
        wr(4'd4, 32'h0000_0000);
        wr(4'd5, 32'h0000_003B);
        wr(4'd6, 32'hCAFE_0000);
        wr(4'd7, 32'h0000_FFFF);
        wr(4'd8, 32'h0000_0080);
        rd(4'd1, r);
        chk("R2 mask readback", r, 32'h0000_000F);

        for (int i = 0; i < NVEC; i++) begin
            access(VECS[i].addr, VECS[i].data, VECS[i].size, VECS[i].write, VECS[i].ifetch, b, g);
            chk($sformatf("R2/R3/R4/R6 vector %0d brk", i), {31'b0, b}, {31'b0, VECS[i].exp});
            chk($sformatf("R9 vector %0d dbg off", i), {31'b0, g}, 32'h0);
            idle(b);
            chk($sformatf("R6 vector %0d single pulse", i), {31'b0, b}, 32'h0);
        end

        // R5 flags sticky / clear
        rd(4'd8, r);
        chk("R5 both flags set", r, 32'h0000_C080);
        wr(4'd8, 32'h0000_0000);
        rd(4'd8, r);
        chk("R5 flags cleared by 0", r, 32'h0);
        // R4 data condition disabled: data mismatch still matches
        access(32'h2000_0000, 32'h1111_1111, 2'b01, 1'b1, 1'b0, b, g);
        chk("R4 data ignored when disabled", {31'b0, b}, 32'h1);
        rd(4'd8, r);
        chk("R5 only flag B set", r, 32'h0000_4000);
        wr(4'd8, 32'h0000_C000);
        rd(4'd8, r);
        chk("R5 writing 1 no effect", r, 32'h0000_4000);
        wr(4'd8, 32'h0000_0000);

        // R10 layout
        wr(4'd8, 32'h0000_FFFF);
        rd(4'd8, r);
        chk("R10 control readback", r, 32'h0000_04C9);
        wr(4'd8, 32'h0000_0000);

        // R9 debug route
        wr(4'd8, 32'h0000_0008);
        access(32'h0000_1000, 32'h0, 2'b11, 1'b0, 1'b1, b, g);
        chk("R9 brk with dbg", {31'b0, b}, 32'h1);
        chk("R9 dbg routed", {31'b0, g}, 32'h1);
        wr(4'd8, 32'h0000_0000);

        // R8 post-execution on A
        wr(4'd8, 32'h0000_0400);
        access(32'h0000_1000, 32'h0, 2'b11, 1'b0, 1'b1, b, g);
        chk("R8 no break before completion", {31'b0, b}, 32'h0);
        idle(b);
        chk("R8 still held", {31'b0, b}, 32'h0);
        insn_done = 1'b1;
        @(negedge clk);
        insn_done = 1'b0;
        chk("R8 break after completion", {31'b0, brk_req}, 32'h1);
        idle(b);
        chk("R8 pulse ends", {31'b0, b}, 32'h0);
        // R8 operand match with post B breaks at once
        wr(4'd8, 32'h0000_0040);
        access(32'h2000_0000, 32'h0, 2'b11, 1'b1, 1'b0, b, g);
        chk("R8 operand immediate", {31'b0, b}, 32'h1);

        // R7 sequential
        wr(4'd8, 32'h0000_0001);
        access(32'h2000_0000, 32'h0, 2'b11, 1'b1, 1'b0, b, g);
        chk("R7 B before arm no break", {31'b0, b}, 32'h0);
        rd(4'd8, r);
        chk("R7 B flag not set unarmed", r, 32'h0000_0001);
        access(32'h0000_1000, 32'h0, 2'b11, 1'b0, 1'b1, b, g);
        chk("R7 A match no break", {31'b0, b}, 32'h0);
        rd(4'd8, r);
        chk("R7 A flag set", r, 32'h0000_8001);
        access(32'h2000_0000, 32'h0, 2'b11, 1'b1, 1'b0, b, g);
        chk("R7 armed B breaks", {31'b0, b}, 32'h1);
        rd(4'd8, r);
        chk("R7 both flags", r, 32'h0000_C001);
        access(32'h2000_0000, 32'h0, 2'b11, 1'b1, 1'b0, b, g);
        chk("R7 arm cleared", {31'b0, b}, 32'h0);

        // R1 reset mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd(4'd8, r);
        chk("R1 ctrl after second reset", r, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule